// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This block sits beside a cache and keeps a short run of blocks that follow the most recent miss. When a lookup misses both the cache and the oldest buffered block, the buffer throws away its contents. It then refills itself with the block addresses that come directly after the missed one and sends a prefetch request for each of them, in ascending order.

Each cache lookup is compared, in the same cycle, against the oldest entry only. If that entry holds its data, the block is returned at once so the cache can fill it. The entry is then freed and reused for the block after the newest one held, which is requested in turn. If the entry matches but its data has not yet come back, the lookup is reported as pending and nothing changes.

Prefetch requests use a valid/ready handshake, and memory answers them in order. Every request carries a small stream epoch that memory echoes back. This lets responses that belong to a discarded stream be dropped.

Top module: `stream_buf`

## Requirements
- R1: After reset no prefetch request is offered, and no lookup reports a hit or pending.
- R2: A valid lookup that misses the cache (lk_cache_hit=0) and does not match the oldest entry restarts the buffer. From the next cycle, requests go out for block addresses M+1 to M+DEPTH in ascending order, where M is the lookup's block address.
- R3: While pf_req_ready is low and no restart occurs, pf_req_valid stays high and pf_req_blk stays unchanged.
- R4: A lookup that misses the cache and matches the oldest entry before its data has arrived sets sb_pending and not sb_hit. It causes no restart and issues no new request.
- R5: A lookup that misses the cache and matches the oldest entry after its data has arrived sets sb_hit and presents that block's data on sb_data in the same cycle. The next entry becomes the oldest, and one request follows for the block after the newest held block.
- R6: Only the oldest entry is compared. A cache-missing lookup whose block is held in a younger entry restarts the buffer, as in R2.
- R7: A lookup with lk_cache_hit=1 never sets sb_hit or sb_pending and leaves the buffer unchanged.
- R8: Each request carries the current epoch on pf_req_epoch, and each restart adds one to it, modulo 2^EPOCH_W. A response is stored only if its pf_rsp_epoch equals the current epoch; otherwise it is dropped. Responses are always accepted and fill entries in request order.
- R9: The block address is lk_addr shifted right by BLK_SHIFT (5, so 32-byte blocks). The low five address bits do not affect matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | A cache lookup is presented this cycle |
| lk_addr | input | ADDR_W | Byte address of the lookup |
| lk_cache_hit | input | 1 | The cache itself hit on this lookup |
| sb_hit | output | 1 | Oldest entry matched with data present |
| sb_pending | output | 1 | Oldest entry matched, data still outstanding |
| sb_data | output | DATA_W | Data of the oldest entry |
| pf_req_valid | output | 1 | Prefetch request offered |
| pf_req_ready | input | 1 | Memory accepts the request |
| pf_req_blk | output | ADDR_W-BLK_SHIFT | Block address requested |
| pf_req_epoch | output | EPOCH_W | Stream epoch of the request |
| pf_rsp_valid | input | 1 | Prefetch response arrives |
| pf_rsp_epoch | input | EPOCH_W | Echoed epoch of the response |
| pf_rsp_data | input | DATA_W | Block data of the response |

## Verification
The hardest situation to reach is a response from a discarded stream arriving after the restart, while the new stream's own requests are still unanswered. The stimulus gets there by holding back the memory model's answers and asserting a fresh miss while old requests are in flight. It then delivers the stale answers first and checks that the new oldest entry is still only pending. A second situation needs care: a restart raised by a block held in a younger entry. It is reached by consuming one hit and then looking up the block two places further on.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Per-entry status bits
    typedef struct packed {
        logic live;    // entry belongs to the current stream
        logic issued;  // request for this block has been accepted
        logic dvalid;  // data for this block has been captured
    } sb_flags_t;

    // Outcome of comparing a lookup with the oldest entry
    typedef enum logic [1:0] {
        LK_NONE    = 2'd0,
        LK_HIT     = 2'd1,
        LK_PEND    = 2'd2,
        LK_RESTART = 2'd3
    } lk_kind_e;

endpackage

// File: rtl/sb_pick.sv
// Finds the first set bit of mask, scanning circularly from base.
module sb_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  mask,
    input  logic [PW-1:0] base,
    output logic          found,
    output logic [PW-1:0] idx
);
    logic [PW-1:0] slot;

    always_comb begin
        found = 1'b0;
        idx   = base;
        slot  = base;
        for (int k = N - 1; k >= 0; k--) begin
            slot = base + PW'(k);
            if (mask[slot]) begin
                found = 1'b1;
                idx   = slot;
            end
        end
    end
endmodule

// File: rtl/sb_head_cmp.sv
// Classifies a lookup against the oldest entry.
module sb_head_cmp #(
    parameter int BLK_W = 27
) (
    input  logic              lk_valid,
    input  logic              lk_cache_hit,
    input  logic [BLK_W-1:0]  lk_blk,
    input  logic [BLK_W-1:0]  head_blk,
    input  logic              head_live,
    input  logic              head_dvalid,
    output sb_pkg::lk_kind_e  kind
);
    always_comb begin
        if (!lk_valid || lk_cache_hit) begin
            kind = sb_pkg::LK_NONE;
        end else if (head_live && (head_blk == lk_blk)) begin
            kind = head_dvalid ? sb_pkg::LK_HIT : sb_pkg::LK_PEND;
        end else begin
            kind = sb_pkg::LK_RESTART;
        end
    end
endmodule

// File: rtl/stream_buf.sv
module stream_buf #(
    parameter int ADDR_W    = 32,
    parameter int DEPTH     = 4,
    parameter int BLK_SHIFT = 5,
    parameter int DATA_W    = 256,
    parameter int EPOCH_W   = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lk_valid,
    input  logic [ADDR_W-1:0]           lk_addr,
    input  logic                        lk_cache_hit,
    output logic                        sb_hit,
    output logic                        sb_pending,
    output logic [DATA_W-1:0]           sb_data,
    output logic                        pf_req_valid,
    input  logic                        pf_req_ready,
    output logic [ADDR_W-BLK_SHIFT-1:0] pf_req_blk,
    output logic [EPOCH_W-1:0]          pf_req_epoch,
    input  logic                        pf_rsp_valid,
    input  logic [EPOCH_W-1:0]          pf_rsp_epoch,
    input  logic [DATA_W-1:0]           pf_rsp_data
);
    import sb_pkg::*;

    localparam int BLK_W = ADDR_W - BLK_SHIFT;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        sb_flags_t [DEPTH-1:0]             flg;
        logic      [DEPTH-1:0][BLK_W-1:0]  blk;
        logic      [DEPTH-1:0][DATA_W-1:0] dat;
        logic      [PTR_W-1:0]             head;
        logic      [EPOCH_W-1:0]           epoch;
    } st_t;

    st_t st_d, st_q;

    logic [BLK_W-1:0]     lk_blk;
    logic [BLK_SHIFT-1:0] lk_offset_unused;
    lk_kind_e             kind;
    logic [DEPTH-1:0]     req_mask, rsp_mask;
    logic                 req_found, rsp_found;
    logic [PTR_W-1:0]     req_idx, rsp_idx;
    logic [PTR_W-1:0]     tail;
    logic                 req_fire, rsp_take;

    assign lk_blk           = lk_addr[ADDR_W-1:BLK_SHIFT];
    assign lk_offset_unused = lk_addr[BLK_SHIFT-1:0];
    assign tail             = st_q.head - PTR_W'(1);

    // Masks of entries waiting for a request / waiting for data
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            req_mask[i] = st_q.flg[i].live && !st_q.flg[i].issued;
            rsp_mask[i] = st_q.flg[i].live && st_q.flg[i].issued && !st_q.flg[i].dvalid;
        end
    end

    sb_pick #(.N(DEPTH), .PW(PTR_W)) u_req_pick (
        .mask  (req_mask),
        .base  (st_q.head),
        .found (req_found),
        .idx   (req_idx)
    );

    sb_pick #(.N(DEPTH), .PW(PTR_W)) u_rsp_pick (
        .mask  (rsp_mask),
        .base  (st_q.head),
        .found (rsp_found),
        .idx   (rsp_idx)
    );

    sb_head_cmp #(.BLK_W(BLK_W)) u_head_cmp (
        .lk_valid     (lk_valid),
        .lk_cache_hit (lk_cache_hit),
        .lk_blk       (lk_blk),
        .head_blk     (st_q.blk[st_q.head]),
        .head_live    (st_q.flg[st_q.head].live),
        .head_dvalid  (st_q.flg[st_q.head].dvalid),
        .kind         (kind)
    );

    assign pf_req_valid = req_found;
    assign pf_req_blk   = st_q.blk[req_idx];
    assign pf_req_epoch = st_q.epoch;
    assign sb_hit       = (kind == LK_HIT);
    assign sb_pending   = (kind == LK_PEND);
    assign sb_data      = st_q.dat[st_q.head];

    assign req_fire = req_found && pf_req_ready;
    assign rsp_take = pf_rsp_valid && rsp_found && (pf_rsp_epoch == st_q.epoch);

    always_comb begin
        st_d = st_q;
        if (kind == LK_RESTART) begin
            st_d.epoch = st_q.epoch + EPOCH_W'(1);
            st_d.head  = '0;
            for (int i = 0; i < DEPTH; i++) begin
                st_d.blk[i]        = lk_blk + BLK_W'(i + 1);
                st_d.flg[i].live   = 1'b1;
                st_d.flg[i].issued = 1'b0;
                st_d.flg[i].dvalid = 1'b0;
            end
        end else begin
            if (req_fire) begin
                st_d.flg[req_idx].issued = 1'b1;
            end
            if (rsp_take) begin
                st_d.flg[rsp_idx].dvalid = 1'b1;
                st_d.dat[rsp_idx]        = pf_rsp_data;
            end
            if (kind == LK_HIT) begin
                // freed oldest slot becomes the newest, one block past the old newest
                st_d.blk[st_q.head]        = st_q.blk[tail] + BLK_W'(1);
                st_d.flg[st_q.head].live   = 1'b1;
                st_d.flg[st_q.head].issued = 1'b0;
                st_d.flg[st_q.head].dvalid = 1'b0;
                st_d.head                  = st_q.head + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sb_check.sv
module sb_check #(
    parameter int ADDR_W    = 32,
    parameter int BLK_SHIFT = 5,
    parameter int EPOCH_W   = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        lk_valid,
    input logic [ADDR_W-1:0]           lk_addr,
    input logic                        lk_cache_hit,
    input logic                        sb_hit,
    input logic                        sb_pending,
    input logic                        pf_req_valid,
    input logic                        pf_req_ready,
    input logic [ADDR_W-BLK_SHIFT-1:0] pf_req_blk,
    input logic [EPOCH_W-1:0]          pf_req_epoch
);
    logic restart;
    assign restart = lk_valid && !lk_cache_hit && !sb_hit && !sb_pending;

    assert_hit_pend_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sb_hit && sb_pending));

    assert_restart_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> pf_req_valid &&
                    (pf_req_blk == $past(lk_addr[ADDR_W-1:BLK_SHIFT]) + 1'b1));

    assert_epoch_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> pf_req_epoch == $past(pf_req_epoch) + 1'b1);

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_req_valid && !pf_req_ready && !restart) |=> pf_req_valid && $stable(pf_req_blk));

    assert_hit_refill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sb_hit |=> pf_req_valid);

    assert_cache_hit_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_cache_hit |-> !sb_hit && !sb_pending);
endmodule

bind stream_buf sb_check #(
    .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .EPOCH_W(EPOCH_W)
) u_sb_check (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_valid     (lk_valid),
    .lk_addr      (lk_addr),
    .lk_cache_hit (lk_cache_hit),
    .sb_hit       (sb_hit),
    .sb_pending   (sb_pending),
    .pf_req_valid (pf_req_valid),
    .pf_req_ready (pf_req_ready),
    .pf_req_blk   (pf_req_blk),
    .pf_req_epoch (pf_req_epoch)
);

// File: tb/sim_stream_buf.sv
`timescale 1ns/100ps
module sim_stream_buf;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lk_valid = 1'b0;
    logic [31:0]  lk_addr = '0;
    logic         lk_cache_hit = 1'b0;
    logic         sb_hit, sb_pending;
    logic [255:0] sb_data;
    logic         pf_req_valid;
    logic         pf_req_ready = 1'b1;
    logic [26:0]  pf_req_blk;
    logic [1:0]   pf_req_epoch;
    logic         pf_rsp_valid = 1'b0;
    logic [1:0]   pf_rsp_epoch = '0;
    logic [255:0] pf_rsp_data = '0;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct { logic [26:0] b; logic [1:0] e; } rq_t;
    rq_t q[$];

    always #2 clk = ~clk;

    stream_buf u0 (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .lk_cache_hit(lk_cache_hit), .sb_hit(sb_hit), .sb_pending(sb_pending),
        .sb_data(sb_data), .pf_req_valid(pf_req_valid), .pf_req_ready(pf_req_ready),
        .pf_req_blk(pf_req_blk), .pf_req_epoch(pf_req_epoch),
        .pf_rsp_valid(pf_rsp_valid), .pf_rsp_epoch(pf_rsp_epoch), .pf_rsp_data(pf_rsp_data)
    );

    function automatic logic [255:0] mkdat(input logic [26:0] b, input logic [1:0] e);
        return {8{{3'b101, e, b} ^ 32'h3C5A_96E1}};
    endfunction

    // Memory-side monitor: records accepted requests just before each rising edge
    always begin
        @(negedge clk);
        #1.5;
        if (rst_n && pf_req_valid && pf_req_ready) q.push_back('{b: pf_req_blk, e: pf_req_epoch});
    end

    task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lookup(input logic [31:0] a, input logic ch,
                          output logic h, output logic p, output logic [255:0] d);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_cache_hit = ch;
        #1;
        h = sb_hit; p = sb_pending; d = sb_data;
        @(negedge clk);
        lk_valid = 1'b0; lk_cache_hit = 1'b0;
    endtask

    task automatic send_rsp(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pf_rsp_valid = 1'b1;
            pf_rsp_epoch = q[0].e;
            pf_rsp_data  = mkdat(q[0].b, q[0].e);
            void'(q.pop_front());
        end
        @(negedge clk);
        pf_rsp_valid = 1'b0;
    endtask

    logic h, p;
    logic [255:0] d;

    task automatic t_reset();
        idle(2); #1;
        check(pf_req_valid == 1'b0, "R1 no request after reset", 256'(pf_req_valid), 256'd0);
        lookup(32'h0, 1'b1, h, p, d);
        check(!h && !p, "R1 no hit/pending after reset", {h, p}, 0);
    endtask

    task automatic t_restart();
        lookup(32'h0000_1000, 1'b0, h, p, d);          // block 0x80
        check(!h && !p, "R2 miss reports nothing", {h, p}, 0);
        idle(6);
        check(q.size() == 4, "R2 four requests", q.size(), 4);
        for (int i = 0; i < 4; i++) begin
            if (i < q.size()) begin
                check(q[i].b == 27'h81 + 27'(i), "R2 ascending block", q[i].b, 27'h81 + 27'(i));
                check(q[i].e == 2'd1, "R8 epoch of first stream", q[i].e, 1);
            end
        end
    endtask

    task automatic t_pending();
        lookup(32'h0000_1020, 1'b0, h, p, d);          // block 0x81, data absent
        check(p && !h, "R4 pending before data", {h, p}, 2'b01);
        idle(3);
        check(q.size() == 4, "R4 no new request on pending", q.size(), 4);
    endtask

    task automatic t_hit();
        send_rsp(4);
        lookup(32'h0000_1031, 1'b0, h, p, d);          // block 0x81, offset 0x11
        check(h && !p, "R9 offset ignored, hit", {h, p}, 2'b10);
        check(d == mkdat(27'h81, 2'd1), "R5 hit data", d, mkdat(27'h81, 2'd1));
        idle(3);
        check(q.size() == 1 && q[0].b == 27'h85, "R5 refill request", (q.size() != 0) ? q[0].b : 0, 27'h85);
        lookup(32'h0000_1040, 1'b0, h, p, d);          // block 0x82 now oldest
        check(h && d == mkdat(27'h82, 2'd1), "R5 head advanced", d, mkdat(27'h82, 2'd1));
        idle(3);
    endtask

    task automatic t_cache_hit();
        lookup(32'h0000_1060, 1'b1, h, p, d);          // block 0x83 with cache hit
        check(!h && !p, "R7 cache hit suppresses buffer", {h, p}, 0);
        lookup(32'h0000_1060, 1'b0, h, p, d);
        check(h && d == mkdat(27'h83, 2'd1), "R7 buffer untouched", d, mkdat(27'h83, 2'd1));
        idle(3);
    endtask

    task automatic t_backpressure();
        pf_req_ready = 1'b0;
        lookup(32'h0000_8000, 1'b0, h, p, d);          // block 0x400, restart
        #1;
        check(pf_req_valid && pf_req_blk == 27'h401, "R2 restart request", pf_req_blk, 27'h401);
        check(pf_req_epoch == 2'd2, "R8 epoch advanced", pf_req_epoch, 2);
        idle(3); #1;
        check(pf_req_valid && pf_req_blk == 27'h401, "R3 request held", pf_req_blk, 27'h401);
        pf_req_ready = 1'b1;
        idle(6);
        check(q.size() == 7, "R3 requests after release", q.size(), 7);
    endtask

    task automatic t_epoch();
        send_rsp(3);                                    // stale answers, epoch 1
        lookup(32'h0000_8020, 1'b0, h, p, d);          // block 0x401
        check(p && !h, "R8 stale responses dropped", {h, p}, 2'b01);
        send_rsp(4);
        lookup(32'h0000_8020, 1'b0, h, p, d);
        check(h && d == mkdat(27'h401, 2'd2), "R8 current data captured", d, mkdat(27'h401, 2'd2));
        idle(4);
    endtask

    task automatic t_only_head();
        lookup(32'h0000_8060, 1'b0, h, p, d);          // block 0x403, younger entry
        check(!h && !p, "R6 younger entry not matched", {h, p}, 0);
        idle(6);
        check(q.size() >= 4, "R6 restart requests", q.size(), 4);
        for (int i = 0; i < 4; i++) begin
            if (q.size() >= 4) begin
                check(q[q.size()-4+i].b == 27'h404 + 27'(i) && q[q.size()-4+i].e == 2'd3,
                      "R6 restart block", q[q.size()-4+i].b, 27'h404 + 27'(i));
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_restart();
        t_pending();
        t_hit();
        t_cache_hit();
        t_backpressure();
        t_epoch();
        t_only_head();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule